// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes one scalar-pipeline instruction that sets the active vector length. Each cycle it may receive a 32-bit instruction word with a valid strobe, along with the value already read from the first source register. If the word is the configuration instruction, the block computes a new vector length and stores it in its own VL register. It also asks the register file to write that length to the destination register. If the instruction is illegal, it raises a trap instead.

The upper limit on the vector length is encoded as an 11-bit unsigned immediate inside the instruction. It is not derived from element width or register grouping. The immediate may not exceed the scalar register width (XLEN, default 64). When the source register is x0, the full limit is chosen. Every result appears on registered outputs one clock after the strobe.

Top module: `vlcfg_unit`

## Requirements
- R1: A word is accepted only when instr_valid is high, bits 6:0 equal 7'b1010111 and bits 14:12 equal 3'b111. Any other word, or any cycle with instr_valid low, gives no trap, no register write and no VL update in the following cycle, and vl_out keeps its value.
- R2: An accepted word with bit 31 set is reserved. One cycle later trap is high, while vl_update and rd_we are low and vl_out is unchanged.
- R3: The length limit is the unsigned value of bits 30:20. A limit above XLEN traps and changes nothing. A limit equal to XLEN is legal.
- R4: When bits 19:15 (rs1) are zero, the new VL equals the limit and rs1_value is ignored.
- R5: When rs1 is non-zero, the new VL is the unsigned minimum of rs1_value and the zero-extended limit.
- R6: When bits 11:7 (rd) are non-zero on a legal instruction, rd_we is high for one cycle, with rd_idx = rd and rd_data = the new VL, zero-extended.
- R7: When rd is zero on a legal instruction, rd_we stays low, yet VL is still updated and vl_update pulses.
- R8: All outputs are registered and appear exactly one clock after the strobe. vl_update, rd_we and trap are single-cycle pulses, and vl_out holds the last legal result. When rd_we is low, rd_idx and rd_data are 0.
- R9: A synchronous active-high reset clears vl_out and all strobes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| rs1_value | input | XLEN | Value read from register rs1 |
| vl_out | output | clog2(XLEN+1) | Current vector length register |
| vl_update | output | 1 | Pulse: VL register was just loaded |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Destination register write data |
| trap | output | 1 | Illegal-instruction trap pulse |

## Verification
The bench targets the legality boundary by issuing limits of exactly XLEN, XLEN+1 and the maximum 2047. An off-by-one compare would either trap on the legal value or accept the first illegal one. It passes an rs1_value with the top bit set, which a signed minimum would turn into a huge or negative length. It also sends a non-zero rs1_value together with rs1 = x0, which a design that ignores the x0 selector would clamp wrongly. Reserved bit-31 words, wrong opcode or function fields, and strobe-low cycles are all checked to leave vl_out untouched and to emit no write. A design that updated state on a trap or decoded loosely would be caught there. The rd = x0 case confirms that VL still changes when the register write is suppressed.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

    localparam logic [6:0] VEC_OPC    = 7'b1010111;
    localparam logic [2:0] CFG_FUNCT  = 3'b111;
    localparam int         LIMIT_W    = 11;
    localparam int         REG_IDX_W  = 5;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_EXEC = 2'd1,
        CLS_TRAP = 2'd2
    } instr_cls_e;

endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
    import vlcfg_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                 valid_i,
    input  logic [31:0]          word_i,
    output instr_cls_e           cls_o,
    output logic [LIMIT_W-1:0]   limit_o,
    output logic [REG_IDX_W-1:0] src_idx_o,
    output logic [REG_IDX_W-1:0] dst_idx_o
);

    localparam logic [LIMIT_W-1:0] MAX_LIMIT = LIMIT_W'(XLEN);

    logic hit;
    logic reserved;
    logic too_big;

    always_comb begin
        limit_o   = word_i[30:20];
        src_idx_o = word_i[19:15];
        dst_idx_o = word_i[11:7];
        hit       = valid_i && (word_i[6:0] == VEC_OPC) && (word_i[14:12] == CFG_FUNCT);
        reserved  = word_i[31];
        too_big   = (limit_o > MAX_LIMIT);
        if (!hit) begin
            cls_o = CLS_NONE;
        end else if (reserved || too_big) begin
            cls_o = CLS_TRAP;
        end else begin
            cls_o = CLS_EXEC;
        end
    end

endmodule

// File: rtl/vlcfg_len.sv
module vlcfg_len
    import vlcfg_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [LIMIT_W-1:0]   limit_i,
    input  logic [REG_IDX_W-1:0] src_idx_i,
    input  logic [XLEN-1:0]      src_val_i,
    output logic [LIMIT_W-1:0]   len_o
);

    logic [XLEN-1:0] limit_ext;
    logic            src_smaller;

    always_comb begin
        limit_ext   = XLEN'(limit_i);
        src_smaller = (src_val_i < limit_ext);
        if (src_idx_i == '0) begin
            len_o = limit_i;
        end else if (src_smaller) begin
            len_o = LIMIT_W'(src_val_i);
        end else begin
            len_o = limit_i;
        end
    end

endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
    import vlcfg_pkg::*;
#(
    parameter  int XLEN = 64,
    localparam int VLW  = $clog2(XLEN + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 instr_valid,
    input  logic [31:0]          instr_word,
    input  logic [XLEN-1:0]      rs1_value,
    output logic [VLW-1:0]       vl_out,
    output logic                 vl_update,
    output logic                 rd_we,
    output logic [REG_IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]      rd_data,
    output logic                 trap
);

    typedef struct packed {
        logic [VLW-1:0]       vl;
        logic                 upd;
        logic                 we;
        logic [REG_IDX_W-1:0] idx;
        logic [XLEN-1:0]      data;
        logic                 trap;
    } unit_state_t;

    instr_cls_e           cls;
    logic [LIMIT_W-1:0]   limit;
    logic [REG_IDX_W-1:0] src_idx;
    logic [REG_IDX_W-1:0] dst_idx;
    logic [LIMIT_W-1:0]   new_len;

    unit_state_t st_d;
    unit_state_t st_q;

    vlcfg_decode #(.XLEN(XLEN)) u_decode (
        .valid_i   (instr_valid),
        .word_i    (instr_word),
        .cls_o     (cls),
        .limit_o   (limit),
        .src_idx_o (src_idx),
        .dst_idx_o (dst_idx)
    );

    vlcfg_len #(.XLEN(XLEN)) u_len (
        .limit_i   (limit),
        .src_idx_i (src_idx),
        .src_val_i (rs1_value),
        .len_o     (new_len)
    );

    always_comb begin
        st_d      = st_q;
        st_d.upd  = 1'b0;
        st_d.we   = 1'b0;
        st_d.idx  = '0;
        st_d.data = '0;
        st_d.trap = 1'b0;
        case (cls)
            CLS_TRAP: begin
                st_d.trap = 1'b1;
            end
            CLS_EXEC: begin
                st_d.vl  = VLW'(new_len);
                st_d.upd = 1'b1;
                if (dst_idx != '0) begin
                    st_d.we   = 1'b1;
                    st_d.idx  = dst_idx;
                    st_d.data = XLEN'(VLW'(new_len));
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vl_out    = st_q.vl;
    assign vl_update = st_q.upd;
    assign rd_we     = st_q.we;
    assign rd_idx    = st_q.idx;
    assign rd_data   = st_q.data;
    assign trap      = st_q.trap;

    // R1: a non-matching opcode never produces any effect on the next cycle
    p_foreign_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (instr_word[6:0] != VEC_OPC) |=> (!trap && !vl_update && !rd_we));

    // R2: a trap pulse excludes any state change
    p_trap_no_effect_r2: assert property (@(posedge clk) disable iff (rst)
        trap |-> (!rd_we && !vl_update));

    // R3: the stored length never exceeds XLEN
    p_vl_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (32'(vl_out) <= 32'(XLEN)));

    // R6: a write carries the freshly loaded length to a non-zero register
    p_write_data_r6: assert property (@(posedge clk) disable iff (rst)
        rd_we |-> (vl_update && rd_idx != '0 && rd_data == XLEN'(vl_out)));

    // R8: without the strobe nothing happens one cycle later
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> (!trap && !vl_update && !rd_we));

    // R8: the length register only moves on an update pulse
    p_vl_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !vl_update |-> (vl_out == $past(vl_out)));

endmodule

// File: tb/tb_vlcfg_unit.sv
module tb_vlcfg_unit;

    localparam int XLEN = 64;
    localparam int VLW  = $clog2(XLEN + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            instr_valid = 1'b0;
    logic [31:0]     instr_word = '0;
    logic [XLEN-1:0] rs1_value = '0;
    logic [VLW-1:0]  vl_out;
    logic            vl_update;
    logic            rd_we;
    logic [4:0]      rd_idx;
    logic [XLEN-1:0] rd_data;
    logic            trap;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    longint unsigned ref_vl = 0;

    always #5ns clk = ~clk;

    vlcfg_unit #(.XLEN(XLEN)) dut (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .rs1_value   (rs1_value),
        .vl_out      (vl_out),
        .vl_update   (vl_update),
        .rd_we       (rd_we),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .trap        (trap)
    );

    function automatic logic [31:0] enc(bit hi, int lim, int s1, int d, int fn, int op);
        return {hi, 11'(lim), 5'(s1), 3'(fn), 5'(d), 7'(op)};
    endfunction

    task automatic compare(string tag, longint unsigned e_vl, bit e_up, bit e_we,
                           int e_idx, longint unsigned e_data, bit e_trap);
        tests++;
        if (64'(vl_out) != e_vl || vl_update != e_up || rd_we != e_we ||
            int'(rd_idx) != e_idx || rd_data != e_data || trap != e_trap) begin
            fails++;
            $display("FAIL %s: got vl=%0d up=%0b we=%0b idx=%0d data=%0d trap=%0b exp vl=%0d up=%0b we=%0b idx=%0d data=%0d trap=%0b",
                     tag, vl_out, vl_update, rd_we, rd_idx, rd_data, trap,
                     e_vl, e_up, e_we, e_idx, e_data, e_trap);
        end
    endtask

    // Drive one cycle, then check the registered response against the model
    task automatic step(string tag, bit v, logic [31:0] w, longint unsigned r);
        bit match, e_trap, e_exec, e_we;
        longint unsigned lim, res;
        int dst;
        @(negedge clk);
        instr_valid = v;
        instr_word  = w;
        rs1_value   = r;
        match  = v && (w[6:0] == 7'b1010111) && (w[14:12] == 3'b111);
        lim    = 64'(w[30:20]);
        e_trap = match && (w[31] || lim > 64'(XLEN));
        e_exec = match && !e_trap;
        dst    = int'(w[11:7]);
        res    = 0;
        e_we   = 1'b0;
        if (e_exec) begin
            if (w[19:15] == 5'd0) res = lim;
            else res = (r < lim) ? r : lim;
            ref_vl = res;
            e_we   = (dst != 0);
        end
        @(negedge clk);
        instr_valid = 1'b0;
        compare(tag, ref_vl, e_exec, e_we, e_we ? dst : 0, e_we ? res : 0, e_trap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R9 reset", 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        step("R4 x0 selects limit",            1, enc(0, 16, 0, 5, 7, 7'h57), 64'd999);
        step("R5 rs1 below limit",             1, enc(0, 16, 3, 6, 7, 7'h57), 64'd10);
        step("R5 rs1 above limit",             1, enc(0, 16, 3, 6, 7, 7'h57), 64'd100);
        step("R5 unsigned top bit",            1, enc(0, 64, 9, 2, 7, 7'h57), 64'hFFFF_FFFF_FFFF_FFF0);
        step("R3 limit equal XLEN",            1, enc(0, 64, 0, 1, 7, 7'h57), 64'd0);
        step("R5 rs1 equal limit",             1, enc(0, 20, 4, 7, 7, 7'h57), 64'd20);
        step("R3 limit XLEN+1 traps",          1, enc(0, 65, 0, 8, 7, 7'h57), 64'd3);
        step("R3 limit 2047 traps",            1, enc(0, 2047, 4, 8, 7, 7'h57), 64'd3);
        step("R2 bit31 reserved",              1, enc(1, 8, 0, 9, 7, 7'h57), 64'd3);
        step("R7 rd x0 still updates",         1, enc(0, 33, 0, 0, 7, 7'h57), 64'd0);
        step("R1 wrong opcode",                1, enc(0, 5, 0, 10, 7, 7'h53), 64'd0);
        step("R1 wrong funct",                 1, enc(0, 5, 0, 10, 3, 7'h57), 64'd0);
        step("R8 strobe low ignored",          0, enc(0, 5, 0, 10, 7, 7'h57), 64'd0);
        step("R6 write to x31",                1, enc(0, 40, 31, 31, 7, 7'h57), 64'd12);
        step("R4 zero limit",                  1, enc(0, 0, 0, 4, 7, 7'h57), 64'd50);
        step("R5 rs1 zero value",              1, enc(0, 30, 2, 4, 7, 7'h57), 64'd0);
        for (int i = 1; i <= 6; i++) begin
            step("R8 back to back", 1, enc(0, 10 * i, i, i, 7, 7'h57), longint'(7 * i));
        end
        step("R8 idle after burst",            0, 32'h0, 64'd0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ref_vl = 0;
        compare("R9 reset after use", 0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule